// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Stretch Arbitration

This block produces the SCL waveform for an I2C master. It drives SCL as an open-drain line: it either pulls the line low or releases it. Each phase is timed by a down-counting baud counter that reloads from a 7-bit value. The counter advances once per machine cycle, which is four core clock periods. SCL is sampled on that same machine-cycle boundary.

A period starts with a low phase of fixed length. When the counter runs out, the line is released. The counter then freezes until the returned SCL level is sampled high. Only then does it reload and time the high phase. A slave that stretches the clock by holding SCL low therefore lengthens the period, and the high time after it lets go is never shorter than one full count. The low phase that follows is timed without looking at the line.

A one-cycle tick marks the end of every phase, so an outer sequencer can move SDA at the right moments. A run request keeps periods going. When the request is dropped, the current period finishes and SCL is left released. Dropping the enable, or a reset, abandons the period at once.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: After a synchronous reset, and in the clock cycle following any cycle with reset high, `scl_pull_low`, `tick` and `busy` are all 0.
- R2: While `en` is 0, `run` has no effect: `busy` and `scl_pull_low` stay 0 and no SCL edge is produced.
- R3: When `en` and `run` are both 1 while idle, `busy` and `scl_pull_low` are 1 from the next clock cycle on, so every sequence opens with a low phase.
- R4: Each low phase holds `scl_pull_low` at 1 for exactly 4*(reload+1) clock cycles, whatever level `scl_in` shows meanwhile.
- R5: After a low phase, SCL is released and the counter is frozen until `scl_in` is sampled high on a machine-cycle boundary. Without stretching, the released interval lasts exactly 4*(reload+2) clock cycles.
- R6: When a slave holds SCL low after release, the time from the first cycle SCL is seen high until the next pull-low lies between 4*reload+5 and 4*reload+8 clock cycles inclusive.
- R7: `tick` is a one-cycle pulse that occurs once at the end of each phase. The low-phase tick falls in the last cycle of `scl_pull_low`=1, and the high-phase tick falls in the last released cycle. Two ticks are never adjacent.
- R8: `reload` is captured only when a phase starts (start of a low phase, or the first high sample). A change during a phase affects only the phases that start afterwards.
- R9: If `run` is 0 when a high phase ends, the block goes idle with SCL released and `busy` 0. A low phase already under way still runs to completion, and so does the release and high phase after it.
- R10: Dropping `en` during a phase abandons it: in the next cycle `scl_pull_low` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low forces idle |
| run | input | 1 | Request to keep generating SCL periods |
| reload | input | 7 | Count value loaded at the start of each phase |
| scl_in | input | 1 | Level of the SCL line as seen at the pin |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| tick | output | 1 | One-cycle pulse at the end of each phase |
| busy | output | 1 | 1 while a period is in progress |

## Verification
The generator is driven with an SCL line that follows the output exactly, with a forced-high line during low phases, with a slave that stretches by a random number of cycles, and with reload values 0, 2, 3, 5, 6 and 9. The non-stretched runs pin the exact low and released lengths. The forced-high run shows that the low phase ignores the line. The random stretches show that the high phase is timed from the first high sample and not from the release. Mid-phase changes to reload, run and en separate capture at phase start from a continuous read, graceful stop from abort, and idle from running.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

    // Core clocks per machine cycle (sampling and counting rate)
    localparam int unsigned SCLG_MC_DIV = 4;
    // Width of the baud reload field
    localparam int unsigned SCLG_RW     = 7;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } sclg_phase_e;

    typedef struct packed {
        logic load;
        logic dec;
    } sclg_cnt_ctl_t;

    function automatic logic sclg_is_timed(sclg_phase_e p);
        return (p == PH_LOW) || (p == PH_HIGH);
    endfunction

endpackage

// File: rtl/sclg_prescale.sv
module sclg_prescale #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic mc_tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || clr)          pcnt <= '0;
        else if (pcnt == LAST)   pcnt <= '0;
        else                     pcnt <= pcnt + 1'b1;
    end

    assign mc_tick = !clr && (pcnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R5
            mc_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                mc_tick |=> !mc_tick);
        end
    endgenerate

endmodule

// File: rtl/sclg_brg.sv
module sclg_brg
    import sclg_pkg::*;
#(
    parameter int unsigned W = SCLG_RW
) (
    input  logic          clk,
    input  logic          rst,
    input  sclg_cnt_ctl_t ctl,
    input  logic [W-1:0]  reload,
    output logic [W-1:0]  cnt,
    output logic          zero
);
    always_ff @(posedge clk) begin
        if (rst)                           cnt <= '0;
        else if (ctl.load)                 cnt <= reload;
        else if (ctl.dec && (cnt != '0))   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4
    dec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.dec |-> !zero);

endmodule

// File: rtl/sclg_phase_fsm.sv
module sclg_phase_fsm
    import sclg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          run,
    input  logic          scl_in,
    input  logic          mc_tick,
    input  logic          cnt_zero,
    output sclg_phase_e   phase,
    output sclg_cnt_ctl_t ctl,
    output logic          tick
);
    sclg_phase_e st, st_nx;
    logic        ovf;

    always_comb begin
        ovf     = mc_tick && cnt_zero && sclg_is_timed(st);
        st_nx   = st;
        ctl     = '0;
        ctl.dec = mc_tick && !cnt_zero && sclg_is_timed(st);
        unique case (st)
            PH_IDLE: if (run) begin
                st_nx    = PH_LOW;
                ctl.load = 1'b1;
            end
            PH_LOW:  if (ovf) st_nx = PH_WAIT;
            PH_WAIT: if (mc_tick && scl_in) begin
                st_nx    = PH_HIGH;
                ctl.load = 1'b1;
            end
            PH_HIGH: if (ovf) begin
                if (run) begin
                    st_nx    = PH_LOW;
                    ctl.load = 1'b1;
                end else begin
                    st_nx    = PH_IDLE;
                end
            end
            default: st_nx = PH_IDLE;
        endcase
        if (!en) begin
            st_nx = PH_IDLE;
            ctl   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PH_IDLE;
        else     st <= st_nx;
    end

    assign phase = st;
    assign tick  = ovf;

    // R2
    dis_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == PH_IDLE));

    // R4
    low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PH_LOW && en && !tick) |=> (st == PH_LOW));

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen
    import sclg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 run,
    input  logic [SCLG_RW-1:0]   reload,
    input  logic                 scl_in,
    output logic                 scl_pull_low,
    output logic                 tick,
    output logic                 busy
);
    sclg_phase_e         phase;
    sclg_cnt_ctl_t       ctl;
    logic                mc_tick;
    logic                cnt_zero;
    logic [SCLG_RW-1:0]  cnt;

    sclg_prescale #(.DIV(SCLG_MC_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase == PH_IDLE),
        .mc_tick (mc_tick)
    );

    sclg_brg #(.W(SCLG_RW)) u_brg (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .reload (reload),
        .cnt    (cnt),
        .zero   (cnt_zero)
    );

    sclg_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .run      (run),
        .scl_in   (scl_in),
        .mc_tick  (mc_tick),
        .cnt_zero (cnt_zero),
        .phase    (phase),
        .ctl      (ctl),
        .tick     (tick)
    );

    assign scl_pull_low = (phase == PH_LOW);
    assign busy         = (phase != PH_IDLE);

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && en && !(mc_tick && scl_in)) |=> (phase == PH_WAIT && $stable(cnt)));

    // R3
    start_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && en && run) |=> (scl_pull_low && busy));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!scl_pull_low && !busy && !tick));

endmodule

// File: tb/sim_i2c_scl_clkgen.sv
`timescale 1ns/1ps
module sim_i2c_scl_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       run = 1'b0;
    logic [6:0] reload = 7'd0;
    logic       scl_in;
    logic       scl_pull_low, tick, busy;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  wd = 1'b0;

    // slave / line model
    bit  force_hi = 1'b0;
    int  stretch_max = 0;
    int  hold_cnt = 0;

    // monitor measurements
    bit  prev_pull = 1'b0, prev_tick = 1'b0;
    int  low_run = 0, rel_run = 0, high_run = 0;
    int  last_low = 0, last_rel = 0, last_high = 0;
    int  nfall = 0, nrise = 0, tick_lo = 0, tick_hi = 0, tick_dbl = 0;

    always #4 clk = ~clk;

    assign scl_in = force_hi | (!scl_pull_low && (hold_cnt == 0));

    i2c_scl_clkgen u0 (
        .clk(clk), .rst(rst), .en(en), .run(run), .reload(reload),
        .scl_in(scl_in), .scl_pull_low(scl_pull_low), .tick(tick), .busy(busy)
    );

    always @(negedge clk) begin
        if (prev_pull && !scl_pull_low) begin
            hold_cnt = (stretch_max > 0) ? int'($urandom_range(stretch_max, 1)) : 0;
            last_low = low_run;
            rel_run  = 0;
            high_run = 0;
            nfall++;
        end else if (hold_cnt > 0) begin
            hold_cnt--;
        end
        if (!prev_pull && scl_pull_low) begin
            last_rel  = rel_run;
            last_high = high_run;
            low_run   = 0;
            nrise++;
        end
        if (scl_pull_low) low_run++;
        else begin
            rel_run++;
            if (force_hi || hold_cnt == 0) high_run++;
        end
        if (tick) begin
            if (scl_pull_low) tick_lo++; else tick_hi++;
            if (prev_tick) tick_dbl++;
        end
        prev_pull = scl_pull_low;
        prev_tick = tick;
    end

    task automatic check_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(string req, int act, int lo, int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_rises(int n);
        int target = nrise + n;
        while (nrise < target && !wd) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; run = 1'b0; force_hi = 1'b0; stretch_max = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic start(int r);
        reload = 7'(r); en = 1'b1; run = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check_eq("R1 pull after reset", int'(scl_pull_low), 0);
        check_eq("R1 busy after reset", int'(busy), 0);
        check_eq("R1 tick after reset", int'(tick), 0);
        start(3);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1 pull after mid-run reset", int'(scl_pull_low), 0);
        check_eq("R1 busy after mid-run reset", int'(busy), 0);
        rst = 1'b0;
    endtask

    task automatic t_disabled();
        int f0;
        do_reset();
        f0 = nfall + nrise;
        reload = 7'd1; en = 1'b0; run = 1'b1;
        repeat (20) @(negedge clk);
        check_eq("R2 busy while disabled", int'(busy), 0);
        check_eq("R2 pull while disabled", int'(scl_pull_low), 0);
        check_eq("R2 no edges while disabled", nfall + nrise - f0, 0);
    endtask

    task automatic t_start();
        do_reset();
        start(2);
        @(negedge clk);
        check_eq("R3 busy on start", int'(busy), 1);
        check_eq("R3 pull on start", int'(scl_pull_low), 1);
    endtask

    task automatic t_basic(int r);
        do_reset();
        start(r);
        wait_rises(3);
        check_eq("R4 low length", last_low, 4 * (r + 1));
        check_eq("R5 released length", last_rel, 4 * (r + 2));
    endtask

    task automatic t_low_ignores_line();
        do_reset();
        force_hi = 1'b1;
        start(6);
        wait_rises(3);
        check_eq("R4 low length with line forced high", last_low, 28);
        force_hi = 1'b0;
    endtask

    task automatic t_stretch();
        int r = 3;
        do_reset();
        stretch_max = 30;
        start(r);
        wait_rises(1);
        for (int k = 0; k < 8; k++) begin
            wait_rises(1);
            check_rng("R6 high time after stretch", last_high, 4 * r + 5, 4 * r + 8);
        end
        stretch_max = 0;
    endtask

    task automatic t_ticks();
        int sf, sr, sl, sh, sd;
        do_reset();
        start(2);
        wait_rises(1);
        @(negedge clk);
        sf = nfall; sr = nrise; sl = tick_lo; sh = tick_hi; sd = tick_dbl;
        wait_rises(4);
        @(negedge clk);
        check_eq("R7 low-phase ticks per fall", tick_lo - sl, nfall - sf);
        check_eq("R7 high-phase ticks per rise", tick_hi - sh, nrise - sr);
        check_eq("R7 no adjacent ticks", tick_dbl - sd, 0);
    endtask

    task automatic t_reload_change();
        do_reset();
        start(2);
        wait_rises(2);
        reload = 7'd9;
        wait_rises(1);
        check_eq("R8 low uses old reload", last_low, 12);
        check_eq("R8 release uses new reload", last_rel, 44);
        wait_rises(1);
        check_eq("R8 next low uses new reload", last_low, 40);
    endtask

    task automatic t_run_drop();
        int f0, r0;
        do_reset();
        start(4);
        wait_rises(2);
        f0 = nfall; r0 = nrise;
        run = 1'b0;
        repeat (80) @(negedge clk);
        check_eq("R9 busy after stop", int'(busy), 0);
        check_eq("R9 line released after stop", int'(scl_pull_low), 0);
        check_eq("R9 low phase completed", nfall - f0, 1);
        check_eq("R9 no new low phase", nrise - r0, 0);
    endtask

    task automatic t_abort();
        do_reset();
        start(10);
        wait_rises(1);
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_eq("R10 pull after abort", int'(scl_pull_low), 0);
        check_eq("R10 busy after abort", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_disabled();
        t_start();
        t_basic(5);
        t_basic(0);
        t_low_ignores_line();
        t_stretch();
        t_ticks();
        t_reload_change();
        t_run_drop();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule